// File: doc/BRIEF.md
# Indirect-Register SCSI Controller Front End

This block is the host-facing register interface and command sequencer of a small SCSI bus interface controller. The host sees only two byte-wide ports in a small device window: an address/status port and a data/value port, one bus word apart. A write to the address port picks one entry of a sixteen-entry bank of 8-bit registers. Later data-port accesses read or write that entry, and every data-port write moves the pointer on by one. A host can therefore load consecutive registers, such as the three count bytes, with one select and a run of writes.

Writes to the command register drive a small sequencer. A reset command and a select-with-attention command post an interrupt and a condition status code. A transfer-information command loads a 24-bit byte count, and the sequencer then counts data-register writes until that count is reached. Target behaviour is reduced to two inputs: a per-ID presence vector and a data-direction result. The interrupt request is a level that follows the pending flag. It is cleared by reading the condition status register or by a control write with the end-of-disconnect bit set.

Top module: `scsi_ifc_front`

## Requirements
- R1: Only byte offset 3 (address/status port) and byte offset 7 (data port) respond. An access at any other offset changes no state and reads 0x00.
- R2: A write to the address port loads the register pointer with the low 4 bits of the written byte. Register indices: 0 own-ID, 1 control, 2 count high, 3 count middle, 4 count low, 5 destination ID, 6 reselect ID, 7 command, 8 data, 9 condition status.
- R3: A read of the address port returns bit 0 = 1, bit 7 = interrupt pending, and all other bits 0.
- R4: A data-port write stores the byte at the pointed register, then increments the pointer modulo 16. A data-port read returns the pointed register and leaves the pointer unchanged.
- R5: A data-port read of register 9 clears the pending interrupt. The `irq` output is equal to the pending flag at all times.
- R6: A write to register 1 with bit 3 set clears the pending interrupt. A write with bit 3 clear leaves it unchanged.
- R7: Command code 0x00 (low 7 bits) sets the interrupt and loads register 9 with 0x00.
- R8: Command code 0x06 sets the interrupt. If `tgt_present[reg5[2:0]]` is 0, it loads register 9 with 0x42. If that bit is 1, it loads 0x8A and sets `phase` to 2 (command phase).
- R9: Command code 0x20 loads the byte count from {reg2, reg3, reg4}, resets the byte position to 0 and clears the pending interrupt.
- R10: While register 7's low 7 bits equal 0x20 (bit 7 ignored), each write to register 8 counts one byte. On the write that reaches the count, the sequencer sets the interrupt, loads register 9 with 0x16 OR dir, and sets `phase` to dir (1 if `tgt_dir_in` is high, else 0).
- R11: In transfer mode, a write to register 8 when the count is 0 or has already been reached is not stored, though the pointer still advances. Such a write sets `xfer_err`, which stays set until reset.
- R12: After reset, all registers, the pointer, `irq`, `xfer_err` and `phase` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Bus access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 3 | Byte offset in the device window |
| acc_wdata | input | 8 | Write byte |
| acc_rdata | output | 8 | Read byte (combinational) |
| tgt_present | input | 8 | Per-ID target presence |
| tgt_dir_in | input | 1 | Target direction result, 1 = data-in |
| irq | output | 1 | Interrupt request level |
| xfer_err | output | 1 | Sticky transfer overrun flag |
| phase | output | 3 | Current bus phase (0 data-out, 1 data-in, 2 command) |

## Verification
The bench goes after the following corner cases:
- **Pointer auto-advance.** Stores are checked across runs of consecutive writes. A design that advanced the pointer on reads, or failed to wrap from 15 to 0, would put later bytes into the wrong registers.
- **Interrupt clear paths.** The bench checks both ways of clearing the interrupt and also a control write without the clear bit. A design that cleared the interrupt on any control write, or on reading some other register, would drop interrupts that should still be pending.
- **Select outcome.** The select command is run with the target absent and with it present. A design that indexed the presence vector with the wrong bits would report the wrong status code.
- **Byte counting.** Transfers are run with counts of 2, 3 and 0, with the single-byte bit set in the command, and with one write past the end. An off-by-one design would raise the interrupt one byte early or late, or would overwrite the data register after the count was reached.

// File: rtl/scsi_fe_pkg.sv
package scsi_fe_pkg;
   typedef logic [7:0] byte_t;

   // register indices inside the bank (count bytes must stay consecutive)
   localparam int unsigned IX_OWNID  = 0;
   localparam int unsigned IX_CTRL   = 1;
   localparam int unsigned IX_CNT_HI = 2;
   localparam int unsigned IX_CNT_LO = 4;
   localparam int unsigned IX_DEST   = 5;
   localparam int unsigned IX_RESEL  = 6;
   localparam int unsigned IX_CMD    = 7;
   localparam int unsigned IX_DATA   = 8;
   localparam int unsigned IX_CSR    = 9;
   localparam int unsigned IX_MIN_BANK = 10;

   // command opcodes, compared after masking the single-byte bit
   localparam byte_t OP_MASK    = 8'h7F;
   localparam byte_t OP_RESET   = 8'h00;
   localparam byte_t OP_SEL_ATN = 8'h06;
   localparam byte_t OP_XFER    = 8'h20;

   localparam int unsigned CTRL_EOD_BIT = 3;
   localparam int unsigned AUX_RDY_BIT  = 0;
   localparam int unsigned AUX_INT_BIT  = 7;

   // condition status codes
   localparam byte_t ST_RESET_DONE = 8'h00;
   localparam byte_t ST_SEL_TMO    = 8'h42;
   localparam byte_t ST_XFER_DONE  = 8'h16;
   localparam byte_t ST_REQ_GROUP  = 8'h88;

   typedef enum logic [2:0] {
      PH_DOUT = 3'd0,
      PH_DIN  = 3'd1,
      PH_CMD  = 3'd2
   } phase_e;
endpackage

// File: rtl/scsi_fe_decode.sv
module scsi_fe_decode #(
   parameter int unsigned ADDR_W   = 3,
   parameter int unsigned PORT_OFF = 3,
   parameter int unsigned STRIDE   = 4
) (
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [ADDR_W-1:0] acc_addr,
   output logic              ptr_wr,
   output logic              stat_rd,
   output logic              val_wr,
   output logic              val_rd
);
   localparam int unsigned DATA_OFF = PORT_OFF + STRIDE;

   if (DATA_OFF >= (1 << ADDR_W)) begin : g_bad_window
      $error("scsi_fe_decode: data port offset outside the address window");
   end

   logic hit_addr, hit_data;

   always_comb begin
      hit_addr = acc_valid && (acc_addr == ADDR_W'(PORT_OFF));
      hit_data = acc_valid && (acc_addr == ADDR_W'(DATA_OFF));
      ptr_wr   = hit_addr &&  acc_write;
      stat_rd  = hit_addr && !acc_write;
      val_wr   = hit_data &&  acc_write;
      val_rd   = hit_data && !acc_write;
   end

   always_comb begin
      a_r1_one_port : assert ($onehot0({ptr_wr, stat_rd, val_wr, val_rd}))
         else $error("a_r1_one_port: more than one port strobe");
   end
endmodule

// File: rtl/scsi_fe_regbank.sv
module scsi_fe_regbank
   import scsi_fe_pkg::*;
#(
   parameter int unsigned NREGS = 16,
   localparam int unsigned SEL_W = $clog2(NREGS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ptr_ld,
   input  byte_t                 ptr_val,
   input  logic                  advance,
   input  logic                  store_en,
   input  byte_t                 wdata,
   input  logic                  csr_ld,
   input  byte_t                 csr_val,
   output logic [SEL_W-1:0]      sel,
   output logic [NREGS-1:0][7:0] regs
);
   if ((NREGS & (NREGS - 1)) != 0 || NREGS < IX_MIN_BANK) begin : g_bad_bank
      $error("scsi_fe_regbank: NREGS must be a power of two of at least 10");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       sel <= '0;
      else if (ptr_ld)  sel <= ptr_val[SEL_W-1:0];
      else if (advance) sel <= sel + SEL_W'(1);
   end

   for (genvar i = 0; i < NREGS; i++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)
            regs[i] <= '0;
         else if (csr_ld && (i == IX_CSR))
            regs[i] <= csr_val;
         else if (store_en && (sel == SEL_W'(i)))
            regs[i] <= wdata;
      end
   end

   a_r4_ptr_step : assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !ptr_ld) |=> (sel == $past(sel) + SEL_W'(1)))
      else $error("a_r4_ptr_step: pointer did not advance");
   a_r2_ptr_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (!advance && !ptr_ld) |=> $stable(sel))
      else $error("a_r2_ptr_hold: pointer moved without a write");
endmodule

// File: rtl/scsi_fe_seq.sv
module scsi_fe_seq
   import scsi_fe_pkg::*;
#(
   parameter int unsigned NREGS     = 16,
   parameter int unsigned CNT_BYTES = 3,
   parameter int unsigned ID_W      = 3,
   localparam int unsigned SEL_W = $clog2(NREGS),
   localparam int unsigned CNT_W = 8 * CNT_BYTES,
   localparam int unsigned NTGT  = 1 << ID_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  val_wr,
   input  logic                  val_rd,
   input  logic [SEL_W-1:0]      sel,
   input  byte_t                 wdata,
   input  logic [NREGS-1:0][7:0] regs,
   input  logic [NTGT-1:0]       tgt_present,
   input  logic                  tgt_dir_in,
   output logic                  store_en,
   output logic                  csr_ld,
   output byte_t                 csr_val,
   output logic                  irq_pend,
   output logic                  err_q,
   output phase_e                phase_q
);
   if (CNT_BYTES < 1 || CNT_BYTES > IX_CNT_LO - IX_CNT_HI + 1) begin : g_bad_cnt
      $error("scsi_fe_seq: CNT_BYTES must be 1 to 3");
   end
   if (ID_W < 1 || ID_W > 7) begin : g_bad_id
      $error("scsi_fe_seq: ID_W must be 1 to 7");
   end

   logic [CNT_W-1:0] cnt_q, bpos_q, cnt_load;
   logic wr_cmd, wr_ctl, wr_data, rd_csr, xfer_mode;
   logic data_xfer, overrun, last_byte, tgt_hit;
   byte_t op;
   phase_e dir_ph;

   always_comb begin
      for (int k = 0; k < CNT_BYTES; k++)
         cnt_load[8*k +: 8] = regs[IX_CNT_LO - k];
   end

   always_comb begin
      wr_cmd    = val_wr && (sel == SEL_W'(IX_CMD));
      wr_ctl    = val_wr && (sel == SEL_W'(IX_CTRL));
      wr_data   = val_wr && (sel == SEL_W'(IX_DATA));
      rd_csr    = val_rd && (sel == SEL_W'(IX_CSR));
      op        = wdata & OP_MASK;
      xfer_mode = ((regs[IX_CMD] & OP_MASK) == OP_XFER);
      data_xfer = wr_data && xfer_mode;
      overrun   = data_xfer && ((cnt_q == '0) || (bpos_q >= cnt_q));
      last_byte = data_xfer && !overrun && ((bpos_q + CNT_W'(1)) == cnt_q);
      store_en  = val_wr && !overrun;
      tgt_hit   = tgt_present[regs[IX_DEST][ID_W-1:0]];
      dir_ph    = tgt_dir_in ? PH_DIN : PH_DOUT;

      csr_ld  = 1'b0;
      csr_val = ST_RESET_DONE;
      if (wr_cmd && op == OP_RESET) begin
         csr_ld  = 1'b1;
         csr_val = ST_RESET_DONE;
      end else if (wr_cmd && op == OP_SEL_ATN) begin
         csr_ld  = 1'b1;
         csr_val = tgt_hit ? (ST_REQ_GROUP | byte_t'(PH_CMD)) : ST_SEL_TMO;
      end else if (last_byte) begin
         csr_ld  = 1'b1;
         csr_val = ST_XFER_DONE | byte_t'(dir_ph);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_pend <= 1'b0;
         err_q    <= 1'b0;
         phase_q  <= PH_DOUT;
         cnt_q    <= '0;
         bpos_q   <= '0;
      end else begin
         if (rd_csr) irq_pend <= 1'b0;
         if (wr_ctl && wdata[CTRL_EOD_BIT]) irq_pend <= 1'b0;
         if (wr_cmd) begin
            case (op)
               OP_RESET:   irq_pend <= 1'b1;
               OP_SEL_ATN: begin
                  irq_pend <= 1'b1;
                  if (tgt_hit) phase_q <= PH_CMD;
               end
               OP_XFER: begin
                  irq_pend <= 1'b0;
                  cnt_q    <= cnt_load;
                  bpos_q   <= '0;
               end
               default: ;
            endcase
         end
         if (data_xfer && !overrun) bpos_q <= bpos_q + CNT_W'(1);
         if (last_byte) begin
            irq_pend <= 1'b1;
            phase_q  <= dir_ph;
         end
         if (overrun) err_q <= 1'b1;
      end
   end

   a_r11_err_sticky : assert property (@(posedge clk) disable iff (!rst_n)
      $past(err_q) |-> err_q)
      else $error("a_r11_err_sticky: error flag dropped");
   a_r10_pos_bounded : assert property (@(posedge clk) disable iff (!rst_n)
      bpos_q <= cnt_q)
      else $error("a_r10_pos_bounded: byte position past count");
   a_r5_csr_read_clears : assert property (@(posedge clk) disable iff (!rst_n)
      rd_csr |=> !irq_pend)
      else $error("a_r5_csr_read_clears: interrupt survived status read");
   a_r7_irq_from_write : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_pend) |-> $past(val_wr))
      else $error("a_r7_irq_from_write: interrupt rose without a write");
   a_r8_phase_legal : assert property (@(posedge clk) disable iff (!rst_n)
      phase_q inside {PH_DOUT, PH_DIN, PH_CMD})
      else $error("a_r8_phase_legal: illegal phase");
endmodule

// File: rtl/scsi_ifc_front.sv
module scsi_ifc_front
   import scsi_fe_pkg::*;
#(
   parameter int unsigned ADDR_W    = 3,
   parameter int unsigned PORT_OFF  = 3,
   parameter int unsigned STRIDE    = 4,
   parameter int unsigned NREGS     = 16,
   parameter int unsigned CNT_BYTES = 3,
   parameter int unsigned ID_W      = 3,
   localparam int unsigned SEL_W = $clog2(NREGS),
   localparam int unsigned NTGT  = 1 << ID_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [7:0]        acc_wdata,
   output logic [7:0]        acc_rdata,
   input  logic [NTGT-1:0]   tgt_present,
   input  logic              tgt_dir_in,
   output logic              irq,
   output logic              xfer_err,
   output logic [2:0]        phase
);
   logic ptr_wr, stat_rd, val_wr, val_rd;
   logic store_en, csr_ld, irq_pend, err_q;
   byte_t csr_val;
   phase_e phase_q;
   logic [SEL_W-1:0] sel;
   logic [NREGS-1:0][7:0] regs;

   scsi_fe_decode #(.ADDR_W(ADDR_W), .PORT_OFF(PORT_OFF), .STRIDE(STRIDE)) u_decode (
      .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
      .ptr_wr(ptr_wr), .stat_rd(stat_rd), .val_wr(val_wr), .val_rd(val_rd)
   );

   scsi_fe_regbank #(.NREGS(NREGS)) u_bank (
      .clk(clk), .rst_n(rst_n), .ptr_ld(ptr_wr), .ptr_val(acc_wdata),
      .advance(val_wr), .store_en(store_en), .wdata(acc_wdata),
      .csr_ld(csr_ld), .csr_val(csr_val), .sel(sel), .regs(regs)
   );

   scsi_fe_seq #(.NREGS(NREGS), .CNT_BYTES(CNT_BYTES), .ID_W(ID_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .val_wr(val_wr), .val_rd(val_rd), .sel(sel),
      .wdata(acc_wdata), .regs(regs), .tgt_present(tgt_present),
      .tgt_dir_in(tgt_dir_in), .store_en(store_en), .csr_ld(csr_ld),
      .csr_val(csr_val), .irq_pend(irq_pend), .err_q(err_q), .phase_q(phase_q)
   );

   always_comb begin
      acc_rdata = 8'h00;
      if (stat_rd) begin
         acc_rdata[AUX_RDY_BIT] = 1'b1;
         acc_rdata[AUX_INT_BIT] = irq_pend;
      end else if (val_rd) begin
         acc_rdata = regs[sel];
      end
   end

   assign irq      = irq_pend;
   assign xfer_err = err_q;
   assign phase    = phase_q;

   a_r3_aux_ready : assert property (@(posedge clk) disable iff (!rst_n)
      stat_rd |-> (acc_rdata[AUX_RDY_BIT] && acc_rdata[AUX_INT_BIT] == irq))
      else $error("a_r3_aux_ready: status byte wrong");
   a_r1_idle_zero : assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> (acc_rdata == 8'h00))
      else $error("a_r1_idle_zero: read data without access");
endmodule

// File: tb/scsi_ifc_front_bench.sv
`timescale 1ns/1ps
module scsi_ifc_front_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic acc_valid = 1'b0, acc_write = 1'b0;
   logic [2:0] acc_addr = '0;
   logic [7:0] acc_wdata = '0;
   logic [7:0] acc_rdata;
   logic [7:0] tgt_present = 8'b0000_1000;
   logic tgt_dir_in = 1'b0;
   logic irq, xfer_err;
   logic [2:0] phase;

   int n_chk = 0, n_fail = 0;
   bit run_cmp = 1'b0;

   // behavioural reference state
   int m_reg[16];
   int m_sel = 0, m_irq = 0, m_err = 0, m_phase = 0, m_cnt = 0, m_pos = 0;

   always #2 clk = ~clk;

   scsi_ifc_front u_scsi_ifc_front (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
      .tgt_present(tgt_present), .tgt_dir_in(tgt_dir_in),
      .irq(irq), .xfer_err(xfer_err), .phase(phase)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   // per-clock comparison of registered outputs against the model
   always @(negedge clk) begin
      if (run_cmp) begin
         check("R5 irq level", int'(irq), m_irq);
         check("R11 xfer_err", int'(xfer_err), m_err);
         check("R8/R10 phase", int'(phase), m_phase);
      end
   end

   function automatic int exp_read(input int addr);
      if (addr == 3) return 1 | (m_irq << 7);
      if (addr == 7) return m_reg[m_sel];
      return 0;
   endfunction

   task automatic model_access(input bit wr, input int addr, input int d);
      int s, op;
      if (addr == 3) begin
         if (wr) m_sel = d & 15;
      end else if (addr == 7) begin
         if (!wr) begin
            if (m_sel == 9) m_irq = 0;
         end else begin
            s = m_sel;
            m_sel = (s + 1) % 16;
            if (s == 8 && (m_reg[7] & 8'h7f) == 8'h20) begin
               if (m_cnt == 0 || m_pos >= m_cnt) m_err = 1;
               else begin
                  m_reg[8] = d;
                  m_pos++;
                  if (m_pos == m_cnt) begin
                     m_irq = 1;
                     m_phase = tgt_dir_in ? 1 : 0;
                     m_reg[9] = 8'h16 | m_phase;
                  end
               end
            end else begin
               m_reg[s] = d;
               if (s == 1 && d[3]) m_irq = 0;
               if (s == 7) begin
                  op = d & 8'h7f;
                  if (op == 8'h00) begin
                     m_irq = 1; m_reg[9] = 8'h00;
                  end else if (op == 8'h06) begin
                     m_irq = 1;
                     if (tgt_present[m_reg[5] & 7]) begin
                        m_reg[9] = 8'h8A; m_phase = 2;
                     end else m_reg[9] = 8'h42;
                  end else if (op == 8'h20) begin
                     m_cnt = (m_reg[2] << 16) | (m_reg[3] << 8) | m_reg[4];
                     m_pos = 0; m_irq = 0;
                  end
               end
            end
         end
      end
   endtask

   task automatic acc(input bit wr, input int addr, input int d, input string req);
      @(negedge clk);
      acc_valid = 1'b1; acc_write = wr; acc_addr = addr[2:0]; acc_wdata = d[7:0];
      #1;
      if (!wr) check(req, int'(acc_rdata), exp_read(addr));
      @(posedge clk);
      #1;
      model_access(wr, addr, d);
      acc_valid = 1'b0; acc_write = 1'b0;
   endtask

   task automatic set_ptr(input int v);   acc(1, 3, v, "R2"); endtask
   task automatic put(input int v);       acc(1, 7, v, "R4"); endtask
   task automatic get(input string req);  acc(0, 7, 0, req);  endtask
   task automatic stat(input string req); acc(0, 3, 0, req);  endtask

   initial begin
      #(4 * 100000);
      n_chk++; n_fail++;
      $display("FAIL R12 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      foreach (m_reg[i]) m_reg[i] = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      run_cmp = 1'b1;
      // R12 reset state
      stat("R12 reset aux");
      for (int i = 0; i < 10; i++) begin
         set_ptr(i); get("R12 reset reg");
      end
      // R2 pointer masking, R4 consecutive stores
      set_ptr(8'h12); put(8'h00); put(8'h00); put(8'h03);
      set_ptr(2); get("R4 cnt hi"); get("R4 read no advance"); set_ptr(4); get("R4 cnt lo");
      // R4 wrap
      set_ptr(15); put(8'h5A); put(8'hC3);
      set_ptr(15); get("R4 reg15"); set_ptr(0); get("R4 wrap to 0");
      // R1 other offsets ignored
      acc(1, 5, 8'hFF, "R1"); acc(1, 0, 8'h01, "R1");
      acc(0, 4, 0, "R1 other offset reads 0");
      set_ptr(0); get("R1 reg0 unchanged");
      // R7 reset command, R3 status, R5 csr read clears
      set_ptr(7); put(8'h00);
      stat("R3 aux int set");
      set_ptr(9); get("R7 csr reset code");
      stat("R5 aux after csr read");
      // R6 control clear
      set_ptr(7); put(8'h80);
      set_ptr(1); put(8'h04);
      stat("R6 no clear without bit3");
      set_ptr(1); put(8'h08);
      stat("R6 cleared by bit3");
      // R8 select, target absent then present
      set_ptr(5); put(8'hF2); put(8'h00); put(8'h06);
      set_ptr(9); get("R8 select timeout");
      set_ptr(5); put(8'h03); put(8'h00); put(8'h86);
      stat("R8 irq on select");
      set_ptr(9); get("R8 command phase requested");
      // R9/R10 transfer count 2, data-in
      tgt_dir_in = 1'b1;
      set_ptr(2); put(8'h00); put(8'h00); put(8'h02);
      set_ptr(7); put(8'h20);
      stat("R9 irq cleared by transfer");
      put(8'h11);
      stat("R10 no irq before count");
      set_ptr(8); put(8'h22);
      set_ptr(9); get("R10 data-in done code");
      set_ptr(8); get("R10 last byte stored");
      // R10/R11 count 3 with single-byte bit, data-out, then overrun
      tgt_dir_in = 1'b0;
      set_ptr(2); put(8'h00); put(8'h00); put(8'h03);
      set_ptr(7); put(8'hA0);
      for (int b = 0; b < 3; b++) begin
         set_ptr(8); put(8'h40 + b);
      end
      set_ptr(9); get("R10 data-out done code");
      set_ptr(8); put(8'h99);
      get("R11 pointer advanced past data");
      set_ptr(8); get("R11 overrun byte not stored");
      // R11 zero count
      set_ptr(2); put(8'h00); put(8'h00); put(8'h00);
      set_ptr(7); put(8'h20);
      put(8'h77);
      set_ptr(8); get("R11 zero count ignored");
      // outside transfer mode data register stores normally
      set_ptr(7); put(8'h01); put(8'h66);
      set_ptr(8); get("R4 data reg plain store");
      stat("R3 final aux");
      repeat (3) @(posedge clk);
      @(negedge clk);
      run_cmp = 1'b0;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule